// File: doc/BRIEF.md
# Upper RAM Bank Controller

This block holds the paging state for the bank-switched RAM that sits behind the top 12 KB of an 8-bit machine's address map, at $D000–$FFFF. The CPU changes that state by touching any of sixteen soft-switch addresses, with either a read or a write. From the address alone the block takes three things: which of two 4 KB banks serves the $D000–$DFFF window, whether reads in the upper area come from RAM or from ROM, and whether writes there reach RAM. The $E000–$FFFF range is not banked.

For each valid bus cycle that falls in the upper area, the block drives select signals for the memory system. These are a RAM select, a ROM select, a flag for the $Dxxx window, a bank-2 flag and a block index. An external alternate-zero-page flag forces block 1. The block also answers reads of two status addresses with the current bank choice and the current read source. All outputs are combinational from the current state and the bus inputs. The state changes on the clock edge that ends a valid soft-switch cycle, and reset is synchronous and active high.

Top module: `lc_bank_ctl`

## Requirements
- R1: After reset, RAM read is off, RAM write is on and bank 2 is selected.
- R2: A soft-switch access (address $C080–$C08F, read or write) selects bank 2 when address bit 3 is 0 and bank 1 when address bit 3 is 1.
- R3: Address bits 1:0 of a soft-switch access set the read source: values 0 and 3 select RAM, values 1 and 2 select ROM.
- R4: A soft-switch access with address bit 0 equal to 0 turns RAM write off and clears the pending-write state.
- R5: RAM write is turned on only by the second of two soft-switch reads at odd addresses with no other soft-switch access between them. A write to any soft-switch address clears the pending state and leaves write enable unchanged. Accesses to other addresses do not affect the pending state.
- R6: For a valid read at $D000–$FFFF, ram_sel is 1 when RAM read is on and rom_sel is 1 when it is off.
- R7: For a valid write at $D000–$FFFF, ram_sel equals the RAM write enable and rom_sel is 0.
- R8: ram_dwin is 1 only for upper accesses in $D000–$DFFF. ram_bank2 is 1 only in that window while bank 2 is selected.
- R9: For upper accesses, ram_block is 1 when alt_zp is 1 and otherwise follows blk_in. Outside the upper area it is 0.
- R10: A valid read of $C011 returns bank-2-selected in st_data bit 7, and a valid read of $C012 returns RAM-read-on in bit 7. The other bits are 0 and st_hit is 1. Any other cycle gives st_hit 0 and st_data 0.
- R11: Cycles with bus_valid low change no state, even at soft-switch addresses.
- R12: Accesses below $D000 assert neither ram_sel nor rom_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_we | input | 1 | 1 for write cycle, 0 for read |
| bus_addr | input | 16 | Bus address |
| alt_zp | input | 1 | Alternate-zero-page flag, forces block 1 |
| blk_in | input | 1 | Normally selected upper-RAM block |
| ram_sel | output | 1 | Upper access goes to RAM |
| rom_sel | output | 1 | Upper read goes to ROM |
| ram_block | output | 1 | Upper-RAM block index |
| ram_dwin | output | 1 | Access is in the banked $Dxxx window |
| ram_bank2 | output | 1 | Banked window uses bank 2 |
| st_hit | output | 1 | Status address read this cycle |
| st_data | output | 8 | Status byte, flag in bit 7 |

## Verification
A bad bank bit appears on the very next $C011 read and on ram_bank2 for the next $Dxxx access. A bad read source appears at once as rom_sel in place of ram_sel, and on $C012. Write enable has no status address, so an error in the pending-write logic can only be seen through ram_sel on the next upper write. For that reason the bench probes with a $D000 write after every switch access. It sweeps every ordered pair of switch addresses in both read and write forms, so each pending-write path is covered within one access of its cause.

// File: rtl/lc_bank_ctl.sv
module lc_bank_ctl #(
  parameter logic [15:0] SW_BASE = 16'hC080,
  parameter logic [15:0] ST_BANK = 16'hC011,
  parameter logic [15:0] ST_READ = 16'hC012,
  parameter logic [3:0]  WIN_D   = 4'hD
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic        alt_zp,
  input  logic        blk_in,
  output logic        ram_sel,
  output logic        rom_sel,
  output logic        ram_block,
  output logic        ram_dwin,
  output logic        ram_bank2,
  output logic        st_hit,
  output logic [7:0]  st_data
);

  logic       rd_en, wr_en, bank2, pre;
  logic       sw_hit, up_hit;
  logic [1:0] act;

  assign sw_hit = bus_valid && (bus_addr[15:4] == SW_BASE[15:4]);
  assign act    = bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en <= 1'b0;
      wr_en <= 1'b1;
      bank2 <= 1'b1;
      pre   <= 1'b0;
    end else if (sw_hit) begin
      bank2 <= !bus_addr[3];
      rd_en <= (act == 2'd0) || (act == 2'd3);
      if (!act[0]) begin
        wr_en <= 1'b0;
        pre   <= 1'b0;
      end else if (bus_we) begin
        pre   <= 1'b0;
      end else begin
        if (pre) wr_en <= 1'b1;
        pre <= 1'b1;
      end
    end
  end

  assign up_hit    = bus_valid && (bus_addr[15:12] >= WIN_D);
  assign ram_sel   = up_hit && (bus_we ? wr_en : rd_en);
  assign rom_sel   = up_hit && !bus_we && !rd_en;
  assign ram_dwin  = up_hit && (bus_addr[15:12] == WIN_D);
  assign ram_bank2 = ram_dwin && bank2;
  assign ram_block = up_hit && (alt_zp || blk_in);

  assign st_hit  = bus_valid && !bus_we && ((bus_addr == ST_BANK) || (bus_addr == ST_READ));
  assign st_data = st_hit ? {((bus_addr == ST_BANK) ? bank2 : rd_en), 7'b0} : 8'h00;

endmodule

module lc_bank_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic [15:0] bus_addr,
  input logic        alt_zp,
  input logic        sw_hit,
  input logic        rd_en,
  input logic        wr_en,
  input logic        bank2,
  input logic        pre,
  input logic        ram_sel,
  input logic        rom_sel,
  input logic        ram_block
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rd_en && wr_en && bank2));

  p_bank_bit_r2: assert property (@(posedge clk) disable iff (rst)
    sw_hit |=> (bank2 == !$past(bus_addr[3])));

  p_even_wr_off_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_hit && !bus_addr[0]) |=> !wr_en);

  p_single_odd_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_hit && bus_addr[0] && !pre && !wr_en) |=> !wr_en);

  p_rom_excl_r6: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> !ram_sel);

  p_block_altzp_r9: assert property (@(posedge clk) disable iff (rst)
    (ram_sel && alt_zp) |-> ram_block);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> $stable({rd_en, wr_en, bank2, pre}));

endmodule

bind lc_bank_ctl lc_bank_ctl_chk u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .alt_zp(alt_zp), .sw_hit(sw_hit), .rd_en(rd_en), .wr_en(wr_en),
  .bank2(bank2), .pre(pre), .ram_sel(ram_sel), .rom_sel(rom_sel),
  .ram_block(ram_block)
);

// File: tb/tb_lc_bank_ctl.sv
module tb_lc_bank_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        alt_zp = 1'b0;
  logic        blk_in = 1'b0;
  logic        ram_sel, rom_sel, ram_block, ram_dwin, ram_bank2, st_hit;
  logic [7:0]  st_data;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  bit mrd, mwr, mbank2, mpre;

  always #5 clk = ~clk;

  lc_bank_ctl dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .alt_zp(alt_zp), .blk_in(blk_in),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .ram_block(ram_block),
    .ram_dwin(ram_dwin), .ram_bank2(ram_bank2), .st_hit(st_hit), .st_data(st_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %h we %0d)", req, act, exp, bus_addr, bus_we);
    end
  endtask

  task automatic drive(input bit v, input bit we, input logic [15:0] a);
    @(negedge clk);
    bus_valid = v;
    bus_we = we;
    bus_addr = a;
    #2;
  endtask

  task automatic model_sw(input bit we, input logic [15:0] a);
    mbank2 = !a[3];
    mrd = (a[1:0] == 2'd0) || (a[1:0] == 2'd3);
    if (!a[0]) begin
      mwr = 1'b0;
      mpre = 1'b0;
    end else if (we) begin
      mpre = 1'b0;
    end else begin
      if (mpre) mwr = 1'b1;
      mpre = 1'b1;
    end
  endtask

  task automatic probe(input string req);
    drive(1'b1, 1'b0, 16'hC011);
    chk({req, "/R10 bank status"}, {st_hit, st_data}, {1'b1, mbank2, 7'b0});
    drive(1'b1, 1'b0, 16'hC012);
    chk({req, "/R10 read status"}, {st_hit, st_data}, {1'b1, mrd, 7'b0});
    drive(1'b1, 1'b1, 16'hD000);
    chk({req, "/R7 write sel"}, {ram_sel, rom_sel}, {mwr, 1'b0});
    drive(1'b1, 1'b0, 16'hD123);
    chk({req, "/R6 read sel"}, {ram_sel, rom_sel, ram_bank2}, {mrd, !mrd, mbank2});
  endtask

  task automatic sw_access(input bit we, input logic [3:0] lo);
    drive(1'b1, we, {12'hC08, lo});
    model_sw(we, {12'hC08, lo});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mrd = 1'b0; mwr = 1'b1; mbank2 = 1'b1; mpre = 1'b0;
    probe("R1 reset");

    // R2 R3 R4 R5: all ordered pairs of switch accesses, read and write forms
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int wa = 0; wa < 2; wa++)
          for (int wb = 0; wb < 2; wb++) begin
            sw_access(wa[0], a[3:0]);
            probe("R2/R3/R4/R5 first");
            sw_access(wb[0], b[3:0]);
            probe("R2/R3/R4/R5 second");
          end

    // R5: non-switch accesses between odd reads do not break the pair
    sw_access(1'b0, 4'h2);
    sw_access(1'b0, 4'h1);
    drive(1'b1, 1'b0, 16'h1234);
    drive(1'b1, 1'b1, 16'hE000);
    sw_access(1'b0, 4'h1);
    probe("R5 interleaved");
    chk("R5 wr on after pair", mwr, 1);

    // R11: invalid cycles at switch addresses change nothing
    sw_access(1'b0, 4'h8);
    for (int k = 0; k < 16; k++) begin
      drive(1'b0, k[0], {12'hC08, k[3:0]});
      chk("R11 idle outputs", {ram_sel, rom_sel, st_hit}, 3'b000);
    end
    probe("R11 idle hold");

    // R6 R7 R8 R9 R12: region sweep over two read states
    for (int s = 0; s < 2; s++) begin
      sw_access(1'b0, s ? 4'h3 : 4'h2);
      sw_access(1'b0, s ? 4'h3 : 4'hA);
      for (int n = 0; n < 16; n++)
        for (int w = 0; w < 2; w++)
          for (int z = 0; z < 4; z++) begin
            bit up, dw;
            alt_zp = z[1];
            blk_in = z[0];
            drive(1'b1, w[0], {n[3:0], 12'h5A7});
            up = (n >= 13);
            dw = (n == 13);
            chk("R6/R7/R12 ram_sel", ram_sel, up && (w[0] ? mwr : mrd));
            chk("R6/R7/R12 rom_sel", rom_sel, up && !w[0] && !mrd);
            chk("R8 dwin", ram_dwin, dw);
            chk("R8 bank2", ram_bank2, dw && mbank2);
            chk("R9 block", ram_block, up && (z[1] || z[0]));
          end
    end

    // R10: neighbours of status addresses and status writes
    drive(1'b1, 1'b0, 16'hC010);
    chk("R10 C010 no hit", {st_hit, st_data}, 9'd0);
    drive(1'b1, 1'b0, 16'hC013);
    chk("R10 C013 no hit", {st_hit, st_data}, 9'd0);
    drive(1'b1, 1'b1, 16'hC011);
    chk("R10 write no hit", {st_hit, st_data}, 9'd0);
    drive(1'b0, 1'b0, 16'hC012);
    chk("R10 invalid no hit", {st_hit, st_data}, 9'd0);

    // R1: reset again from a changed state
    sw_access(1'b0, 4'hB);
    @(negedge clk); rst = 1'b1; bus_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    mrd = 1'b0; mwr = 1'b1; mbank2 = 1'b1; mpre = 1'b0;
    probe("R1 re-reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule